// File: doc/BRIEF.md
# Snooping MSI Cache Block Controller

This controller keeps the coherence state of a small group of cache blocks for one core attached to a single ordered snooping bus. The core presents loads, stores and replacements through a valid/ready handshake. A request that can finish at once is reported as a hit one cycle later. A request that needs the bus causes the controller to issue a GetS, GetM or PutM and to park the block in a state that waits for data.

The bus has two atomic properties. A request is ordered in the cycle it is issued. No other request for the same block appears until the current transaction's data has arrived. The controller therefore changes a block's state in the same cycle it issues the request. It watches other cores' requests and supplies data when it holds a block in Modified. It flags as an error any event that these bus rules forbid.

Each block carries a 3-bit state: Invalid=0, Shared=1, Modified=2, waiting-for-data-to-Shared=3, Invalid-waiting-for-data-to-Modified=4 and Shared-waiting-for-data-to-Modified=5. The state of all blocks is brought out so that they can be observed.

Top module: `msi_block_ctrl`

## Requirements
- R1: After reset every block is Invalid (0), `core_ready` is high, and `req_valid`, `resp_valid`, `err` and `core_hit_mask` are all zero.
- R2: A load accepted on an Invalid block moves it to state 3 and, in the next cycle, raises `req_valid` with `req_type`=0 (GetS) and the block's index. When data arrives for it, the block goes to Shared (1) and its bit in `core_hit_mask` is set in the next cycle.
- R3: A store accepted on an Invalid block moves it to state 4 and issues GetM (`req_type`=1). When data arrives, the block goes to Modified (2) and its hit bit is set.
- R4: A store accepted on a Shared block moves it to state 5 and issues GetM. In state 5 loads are accepted and hit, while stores and replacements are held off with `core_ready` low. When data arrives, the block goes to Modified and its hit bit is set.
- R5: A load to a Shared or Modified block, or a store to a Modified block, sets that block's hit bit in the next cycle, issues no bus request and leaves the state unchanged.
- R6: Replacing a Shared block moves it to Invalid with no bus request. Replacing a Modified block moves it to Invalid and issues PutM (`req_type`=2), which carries the write-back to memory. Replacing an Invalid block issues nothing and leaves it Invalid.
- R7: In Modified, another core's GetS gives a response with data to the requestor and to memory and moves the block to Shared. Another core's GetM gives a response with data to the requestor only and moves the block to Invalid.
- R8: In Shared, another core's GetM moves the block to Invalid with no response. Another core's GetS has no effect on a Shared or an Invalid block.
- R9: `core_ready` is low when the addressed block is in state 3 or 4. It is also low when a snooped request or a data arrival in the same cycle targets the addressed block, and the held request is then not accepted.
- R10: `err` pulses in the next cycle, and the state is not changed by the offending event, in three cases: another core's request seen on a block in state 3, 4 or 5; data arriving for a block in a stable state; another core's PutM seen on a Modified block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_valid | input | 1 | Core request present |
| core_op | input | 2 | 0 load, 1 store, 2 replacement |
| core_idx | input | IDX_W | Block addressed by the core |
| core_ready | output | 1 | Request can be accepted this cycle |
| core_hit_mask | output | NUM_BLOCKS | One bit per block that completed a core access as a hit |
| req_valid | output | 1 | Own bus request issued |
| req_type | output | 2 | 0 GetS, 1 GetM, 2 PutM |
| req_idx | output | IDX_W | Block of the own request |
| snp_valid | input | 1 | Another core's request on the bus |
| snp_type | input | 2 | 0 GetS, 1 GetM, 2 PutM |
| snp_idx | input | IDX_W | Block of the snooped request |
| dat_valid | input | 1 | Data response for an own request |
| dat_idx | input | IDX_W | Block the data belongs to |
| resp_valid | output | 1 | Controller supplies block data |
| resp_to_req | output | 1 | Data goes to the requestor |
| resp_to_mem | output | 1 | Data goes to memory |
| resp_idx | output | IDX_W | Block of the response |
| err | output | 1 | Forbidden event seen |
| blk_state | output | 3*NUM_BLOCKS | State of all blocks, block i at bits 3i+2:3i |

## Verification
The assertions assume that the bus environment delivers at most one snooped request and one data response per cycle. They also assume it honours the atomic-transaction rule, so that data for a block comes only after this controller has issued a request for it. The bench drives one directed event per cycle and sends data only to blocks in a waiting state. The exception is the error scenario, which breaks these rules on purpose. The properties checked there concern only the state encoding, the request types and the hold-off of the handshake, so deliberate violations do not trip them.

// File: rtl/msi_block_ctrl.sv
module msi_block_ctrl #(
  parameter int NUM_BLOCKS = 4,
  localparam int IDX_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    core_valid,
  input  logic [1:0]              core_op,
  input  logic [IDX_W-1:0]        core_idx,
  output logic                    core_ready,
  output logic [NUM_BLOCKS-1:0]   core_hit_mask,
  output logic                    req_valid,
  output logic [1:0]              req_type,
  output logic [IDX_W-1:0]        req_idx,
  input  logic                    snp_valid,
  input  logic [1:0]              snp_type,
  input  logic [IDX_W-1:0]        snp_idx,
  input  logic                    dat_valid,
  input  logic [IDX_W-1:0]        dat_idx,
  output logic                    resp_valid,
  output logic                    resp_to_req,
  output logic                    resp_to_mem,
  output logic [IDX_W-1:0]        resp_idx,
  output logic                    err,
  output logic [3*NUM_BLOCKS-1:0] blk_state
);
  localparam logic [2:0] ST_I = 3'd0, ST_S = 3'd1, ST_M = 3'd2,
                         ST_ISD = 3'd3, ST_IMD = 3'd4, ST_SMD = 3'd5;
  localparam logic [1:0] OP_LD = 2'd0, OP_ST = 2'd1, OP_RP = 2'd2;
  localparam logic [1:0] B_GETS = 2'd0, B_GETM = 2'd1, B_PUTM = 2'd2;

  logic [2:0] st [NUM_BLOCKS];

  wire [2:0] cur    = st[core_idx];
  wire [2:0] snp_st = st[snp_idx];
  wire [2:0] dat_st = st[dat_idx];

  wire bus_busy = (snp_valid && snp_idx == core_idx) ||
                  (dat_valid && dat_idx == core_idx);

  assign core_ready = !bus_busy && cur != ST_ISD && cur != ST_IMD &&
                      !(cur == ST_SMD && core_op != OP_LD);
  wire acc = core_valid && core_ready;

  logic [2:0] acc_next;
  logic       acc_req, acc_hit;
  logic [1:0] acc_type;
  always_comb begin
    acc_next = cur;
    acc_req  = 1'b0;
    acc_hit  = 1'b0;
    acc_type = B_GETS;
    case (core_op)
      OP_LD: if (cur == ST_I) begin acc_next = ST_ISD; acc_req = 1'b1; end
             else acc_hit = 1'b1;
      OP_ST: case (cur)
               ST_I: begin acc_next = ST_IMD; acc_req = 1'b1; acc_type = B_GETM; end
               ST_S: begin acc_next = ST_SMD; acc_req = 1'b1; acc_type = B_GETM; end
               ST_M: acc_hit = 1'b1;
               default: ;
             endcase
      OP_RP: case (cur)
               ST_S: acc_next = ST_I;
               ST_M: begin acc_next = ST_I; acc_req = 1'b1; acc_type = B_PUTM; end
               default: ;
             endcase
      default: ;
    endcase
  end

  logic [2:0] snp_next;
  logic       snp_to_req, snp_to_mem, snp_err;
  always_comb begin
    snp_next   = snp_st;
    snp_to_req = 1'b0;
    snp_to_mem = 1'b0;
    snp_err    = 1'b0;
    if (snp_valid)
      case (snp_st)
        ST_M: case (snp_type)
                B_GETS: begin snp_next = ST_S; snp_to_req = 1'b1; snp_to_mem = 1'b1; end
                B_GETM: begin snp_next = ST_I; snp_to_req = 1'b1; end
                default: snp_err = 1'b1;
              endcase
        ST_S: if (snp_type == B_GETM) snp_next = ST_I;
        ST_ISD, ST_IMD, ST_SMD: snp_err = 1'b1;
        default: ;
      endcase
  end

  wire       dat_fill = dat_valid && (dat_st == ST_ISD || dat_st == ST_IMD || dat_st == ST_SMD);
  wire       dat_err  = dat_valid && !dat_fill;
  wire [2:0] dat_next = (dat_st == ST_ISD) ? ST_S : ST_M;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_BLOCKS; i++) st[i] <= ST_I;
    end else begin
      for (int i = 0; i < NUM_BLOCKS; i++) begin
        if (dat_fill && dat_idx == IDX_W'(i))
          st[i] <= dat_next;
        else if (snp_valid && snp_idx == IDX_W'(i))
          st[i] <= snp_next;
        else if (acc && core_idx == IDX_W'(i))
          st[i] <= acc_next;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_hit_mask <= '0;
      req_valid     <= 1'b0;
      req_type      <= B_GETS;
      req_idx       <= '0;
      resp_valid    <= 1'b0;
      resp_to_req   <= 1'b0;
      resp_to_mem   <= 1'b0;
      resp_idx      <= '0;
      err           <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_BLOCKS; i++)
        core_hit_mask[i] <= (acc && acc_hit && core_idx == IDX_W'(i)) ||
                            (dat_fill && dat_idx == IDX_W'(i));
      req_valid   <= acc && acc_req;
      req_type    <= acc_type;
      req_idx     <= core_idx;
      resp_valid  <= snp_to_req;
      resp_to_req <= snp_to_req;
      resp_to_mem <= snp_to_mem;
      resp_idx    <= snp_idx;
      err         <= snp_err || dat_err;
    end
  end

  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_out
    assign blk_state[3*g +: 3] = st[g];
  end
endmodule

// File: rtl/msi_block_ctrl_chk.sv
module msi_block_ctrl_chk #(
  parameter int NUM_BLOCKS = 4,
  localparam int IDX_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    core_valid,
  input logic [1:0]              core_op,
  input logic [IDX_W-1:0]        core_idx,
  input logic                    core_ready,
  input logic [NUM_BLOCKS-1:0]   core_hit_mask,
  input logic                    req_valid,
  input logic [1:0]              req_type,
  input logic [IDX_W-1:0]        req_idx,
  input logic                    snp_valid,
  input logic [1:0]              snp_type,
  input logic [IDX_W-1:0]        snp_idx,
  input logic                    dat_valid,
  input logic [IDX_W-1:0]        dat_idx,
  input logic                    resp_valid,
  input logic                    resp_to_req,
  input logic                    resp_to_mem,
  input logic [IDX_W-1:0]        resp_idx,
  input logic                    err,
  input logic [3*NUM_BLOCKS-1:0] blk_state
);
  wire [2:0] req_st  = blk_state[3*req_idx +: 3];
  wire [2:0] resp_st = blk_state[3*resp_idx +: 3];
  wire [2:0] core_st = blk_state[3*core_idx +: 3];

  a_r2_gets_waits_shared: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_type == 2'd0 |-> req_st == 3'd3);

  a_r3_getm_waits_modified: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_type == 2'd1 |-> req_st == 3'd4 || req_st == 3'd5);

  a_r6_putm_left_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_type == 2'd2 |-> req_st == 3'd0);

  a_r6_req_type_legal: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_type != 2'd3);

  a_r7_resp_gives_up_modified: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> resp_to_req && resp_st != 3'd2);

  a_r9_hold_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    core_valid && (core_st == 3'd3 || core_st == 3'd4) |-> !core_ready);

  a_r4_store_held_in_upgrade: assert property (@(posedge clk) disable iff (!rst_n)
    core_valid && core_st == 3'd5 && core_op != 2'd0 |-> !core_ready);

  a_r5_hit_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(core_hit_mask) <= 2);

  always @(posedge clk)
    if (rst_n)
      for (int i = 0; i < NUM_BLOCKS; i++)
        a_r1_state_code_legal: assert (blk_state[3*i +: 3] <= 3'd5);
endmodule

bind msi_block_ctrl msi_block_ctrl_chk #(.NUM_BLOCKS(NUM_BLOCKS)) u_chk (.*);

// File: tb/msi_block_ctrl_tb.sv
module msi_block_ctrl_tb;
  localparam int NB = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic core_valid = 1'b0;
  logic [1:0] core_op = 2'd0;
  logic [1:0] core_idx = 2'd0;
  logic core_ready;
  logic [NB-1:0] core_hit_mask;
  logic req_valid;
  logic [1:0] req_type;
  logic [1:0] req_idx;
  logic snp_valid = 1'b0;
  logic [1:0] snp_type = 2'd0;
  logic [1:0] snp_idx = 2'd0;
  logic dat_valid = 1'b0;
  logic [1:0] dat_idx = 2'd0;
  logic resp_valid, resp_to_req, resp_to_mem;
  logic [1:0] resp_idx;
  logic err;
  logic [3*NB-1:0] blk_state;

  int total = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  msi_block_ctrl #(.NUM_BLOCKS(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .core_valid(core_valid), .core_op(core_op),
    .core_idx(core_idx), .core_ready(core_ready), .core_hit_mask(core_hit_mask),
    .req_valid(req_valid), .req_type(req_type), .req_idx(req_idx),
    .snp_valid(snp_valid), .snp_type(snp_type), .snp_idx(snp_idx),
    .dat_valid(dat_valid), .dat_idx(dat_idx), .resp_valid(resp_valid),
    .resp_to_req(resp_to_req), .resp_to_mem(resp_to_mem), .resp_idx(resp_idx),
    .err(err), .blk_state(blk_state));

  function automatic int st(input int i);
    return int'(blk_state[3*i +: 3]);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic core_do(input logic [1:0] op, input logic [1:0] idx);
    @(negedge clk); core_valid = 1'b1; core_op = op; core_idx = idx;
    @(negedge clk); core_valid = 1'b0;
  endtask

  task automatic snoop(input logic [1:0] t, input logic [1:0] idx);
    @(negedge clk); snp_valid = 1'b1; snp_type = t; snp_idx = idx;
    @(negedge clk); snp_valid = 1'b0;
  endtask

  task automatic data(input logic [1:0] idx);
    @(negedge clk); dat_valid = 1'b1; dat_idx = idx;
    @(negedge clk); dat_valid = 1'b0;
  endtask

  task automatic t_reset;
    for (int i = 0; i < NB; i++) chk("R1", "state", st(i), 0);
    chk("R1", "ready", int'(core_ready), 1);
    chk("R1", "outputs", int'({req_valid, resp_valid, err}), 0);
    chk("R1", "hit mask", int'(core_hit_mask), 0);
  endtask

  task automatic t_load_miss;
    core_do(2'd0, 2'd0);
    chk("R2", "req", int'({req_valid, req_type, req_idx}), 'b1_00_00);
    chk("R2", "state", st(0), 3);
    chk("R2", "hit", int'(core_hit_mask), 0);
    data(2'd0);
    chk("R2", "state after data", st(0), 1);
    chk("R2", "hit after data", int'(core_hit_mask), 'b0001);
  endtask

  task automatic t_store_miss;
    core_do(2'd1, 2'd1);
    chk("R3", "req", int'({req_valid, req_type, req_idx}), 'b1_01_01);
    chk("R3", "state", st(1), 4);
    @(negedge clk); core_valid = 1'b1; core_op = 2'd0; core_idx = 2'd1; #1;
    chk("R9", "ready in IM_D", int'(core_ready), 0);
    @(negedge clk); core_valid = 1'b0;
    chk("R9", "no hit while held", int'(core_hit_mask), 0);
    data(2'd1);
    chk("R3", "state after data", st(1), 2);
    chk("R3", "hit after data", int'(core_hit_mask), 'b0010);
  endtask

  task automatic t_upgrade;
    core_do(2'd1, 2'd0);
    chk("R4", "req", int'({req_valid, req_type, req_idx}), 'b1_01_00);
    chk("R4", "state", st(0), 5);
    @(negedge clk); core_valid = 1'b1; core_op = 2'd0; core_idx = 2'd0; #1;
    chk("R4", "load ready in SM_D", int'(core_ready), 1);
    @(negedge clk); core_valid = 1'b0;
    chk("R4", "load hit in SM_D", int'(core_hit_mask), 'b0001);
    core_op = 2'd1; core_valid = 1'b1; #1;
    chk("R4", "store ready in SM_D", int'(core_ready), 0);
    core_op = 2'd2; #1;
    chk("R4", "replace ready in SM_D", int'(core_ready), 0);
    core_valid = 1'b0;
    data(2'd0);
    chk("R4", "state after data", st(0), 2);
    chk("R4", "hit after data", int'(core_hit_mask), 'b0001);
  endtask

  task automatic t_hits;
    core_do(2'd0, 2'd1);
    chk("R5", "load hit M", int'(core_hit_mask), 'b0010);
    chk("R5", "no req", int'(req_valid), 0);
    core_do(2'd1, 2'd1);
    chk("R5", "store hit M", int'(core_hit_mask), 'b0010);
    chk("R5", "state kept", st(1), 2);
  endtask

  task automatic t_snoop;
    snoop(2'd0, 2'd1);
    chk("R7", "GetS resp", int'({resp_valid, resp_to_req, resp_to_mem, resp_idx}), 'b111_01);
    chk("R7", "state after GetS", st(1), 1);
    snoop(2'd0, 2'd1);
    chk("R8", "GetS in S resp", int'(resp_valid), 0);
    chk("R8", "GetS in S state", st(1), 1);
    snoop(2'd1, 2'd1);
    chk("R8", "GetM in S resp", int'(resp_valid), 0);
    chk("R8", "GetM in S state", st(1), 0);
    snoop(2'd1, 2'd0);
    chk("R7", "GetM resp", int'({resp_valid, resp_to_req, resp_to_mem, resp_idx}), 'b110_00);
    chk("R7", "state after GetM", st(0), 0);
    snoop(2'd0, 2'd1);
    chk("R8", "GetS in I", int'({resp_valid, err}), 0);
  endtask

  task automatic t_replace;
    core_do(2'd0, 2'd2); data(2'd2);
    core_do(2'd2, 2'd2);
    chk("R6", "replace S req", int'(req_valid), 0);
    chk("R6", "replace S state", st(2), 0);
    core_do(2'd1, 2'd3); data(2'd3);
    core_do(2'd2, 2'd3);
    chk("R6", "replace M req", int'({req_valid, req_type, req_idx}), 'b1_10_11);
    chk("R6", "replace M state", st(3), 0);
    core_do(2'd2, 2'd3);
    chk("R6", "replace I req", int'(req_valid), 0);
    chk("R6", "replace I state", st(3), 0);
  endtask

  task automatic t_ready_block;
    core_do(2'd0, 2'd2); data(2'd2);
    @(negedge clk);
    core_valid = 1'b1; core_op = 2'd0; core_idx = 2'd2;
    snp_valid = 1'b1; snp_type = 2'd0; snp_idx = 2'd2; #1;
    chk("R9", "ready with snoop same block", int'(core_ready), 0);
    @(negedge clk); snp_valid = 1'b0; core_valid = 1'b0;
    chk("R9", "held request not taken", int'(core_hit_mask), 0);
  endtask

  task automatic t_errors;
    core_do(2'd1, 2'd2);
    chk("R4", "upgrade from S", st(2), 5);
    snoop(2'd0, 2'd2);
    chk("R10", "snoop in transient err", int'(err), 1);
    chk("R10", "state kept", st(2), 5);
    data(2'd2);
    chk("R10", "err cleared", int'(err), 0);
    data(2'd2);
    chk("R10", "data in stable err", int'(err), 1);
    chk("R10", "stable state kept", st(2), 2);
    snoop(2'd2, 2'd2);
    chk("R10", "PutM in M err", int'(err), 1);
    chk("R10", "M kept", st(2), 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_load_miss;
    t_store_miss;
    t_upgrade;
    t_hits;
    t_snoop;
    t_replace;
    t_ready_block;
    t_errors;
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule